// File: doc/BRIEF.md
# Framed 16-bit Link Packet Receiver

This block sits behind an 8b/10b decoder that hands over one 16-bit symbol per clock, together with a control flag for each byte lane. It recognises the control-symbol pairs that frame a packet, rebuilds the packet as 32-bit words with start and end flags on a valid/ready stream, and checks the 16-bit CRC word that follows each packet. Pause and resume symbols for flow control may arrive at any time, even inside a packet. They are reported as single-cycle pulses and leave the packet in progress untouched.

Idle fill between packets, or inside a packet while the sender stalls, is skipped silently and does not disturb word alignment. Error and loss-of-signal symbols abort an open packet. A new start marker closes a packet that is still open, with an error flag. Data outside any packet is counted and dropped. The output stage holds one word. If a new word arrives while that word has not been taken, the rest of the packet is thrown away and an overrun pulse is raised. The CRC check still runs to completion.

Top module: `link_pkt_rx`

## Requirements
- R1: A fill symbol is ignored in any state and does not shift word alignment. A fill symbol has `sym_k_hi`=1, `sym_k_lo`=0, high byte `sym_data[15:8]`=0xBC and low byte `sym_data[7:0]`=0xC5.
- R2: Packet framing and word assembly work as follows.
  - A start symbol has both flags set and both bytes 0xDC. An end symbol has both flags set and both bytes 0x9C. A data symbol has both flags clear.
  - Data symbols are paired in order: the first symbol after start is bits [15:0] of the word and the second is bits [31:16].
  - A word is presented, registered, in the cycle after the symbol that completes the next word. The last word is presented in the cycle after the CRC symbol.
  - `out_sop` marks the first word of a packet and `out_eop` marks the last.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF.
  - Each data symbol is fed in most significant bit first, 16 bits per step.
  - The data symbol that follows the end symbol is compared with the CRC register.
  - On a mismatch, `crc_error` is high for one cycle, in the cycle the last word is presented.
- R4: A resume symbol (both flags set, both bytes 0x5C) gives a one-cycle `xon_pulse` in the next cycle. A pause symbol (both bytes 0x7C) does the same on `xoff_pulse`. Neither disturbs an open packet.
- R5: A fault symbol is any lane whose control flag is set and whose byte is 0x00 or 0xFF.
  - Inside a packet, a fault symbol aborts the packet. So does an end symbol after an odd number of data symbols.
  - On an abort, the pending word is presented with `out_eop` and `out_err` set and no CRC check is made.
  - Outside a packet, a fault symbol is ignored.
- R6: A start symbol that arrives while a packet is open closes the old packet: its pending word is presented with `out_eop` and `out_err` set. The new packet then begins with a fresh CRC.
- R7: Each data symbol outside a packet adds one to `stray_count`, which saturates at its maximum value, and produces no output.
- R8: Output backpressure is handled as follows.
  - While `out_valid` is high and `out_ready` is low, the presented word stays stable.
  - If a new word is due while the output is blocked, that word and the rest of the packet are dropped.
  - `overrun` is high for one cycle when the drop begins, and `crc_error` is still reported.
- R9: While reset is asserted, `out_valid`, the pulses and `stray_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_data | input | 16 | Symbol, bits [7:0] are the earlier byte on the line |
| sym_k_lo | input | 1 | Control flag of the low byte |
| sym_k_hi | input | 1 | Control flag of the high byte |
| out_data | output | 32 | Reassembled word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_err | output | 1 | Packet was aborted or cut short |
| out_valid | output | 1 | Word is presented |
| out_ready | input | 1 | Consumer takes the word |
| crc_error | output | 1 | One-cycle pulse, CRC mismatch |
| xon_pulse | output | 1 | One-cycle pulse, resume symbol seen |
| xoff_pulse | output | 1 | One-cycle pulse, pause symbol seen |
| overrun | output | 1 | One-cycle pulse, packet tail dropped |
| stray_count | output | STRAY_W | Saturating count of data symbols outside packets |

## Verification
The assertions assume that every clock carries exactly one symbol and that `out_ready` does not depend combinationally on `out_valid`. They also assume that resume and pause never arrive in the same symbol, which holds because the two codes differ. The stimulus is drawn only from the listed symbol codes and plain data. The CRC symbol is always a data symbol placed directly after the end symbol, or after fill that follows it. `out_ready` is changed only at the falling edge, away from the sampling edge.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;

  localparam logic [7:0] KC_FILL_HI = 8'hBC;
  localparam logic [7:0] DC_FILL_LO = 8'hC5;
  localparam logic [7:0] KC_SOP     = 8'hDC;
  localparam logic [7:0] KC_EOP     = 8'h9C;
  localparam logic [7:0] KC_RESUME  = 8'h5C;
  localparam logic [7:0] KC_PAUSE   = 8'h7C;
  localparam logic [7:0] KC_FAULT   = 8'h00;
  localparam logic [7:0] KC_LOSS    = 8'hFF;

  typedef enum logic [2:0] {
    SYM_DATA,
    SYM_FILL,
    SYM_SOP,
    SYM_EOP,
    SYM_RESUME,
    SYM_PAUSE,
    SYM_FAULT,
    SYM_OTHER
  } sym_cls_t;

  typedef enum logic [1:0] {
    FR_OUT,
    FR_LO,
    FR_HI,
    FR_CHK
  } fr_state_t;

  typedef struct packed {
    logic [31:0] data;
    logic        sop;
    logic        eop;
    logic        err;
  } beat_t;

  // One parallel CRC step over a 16-bit symbol, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                             input logic [15:0] sym,
                                             input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int b = 15; b >= 0; b--) begin
      fb = c[15] ^ sym[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/link_sym_decode.sv
module link_sym_decode
  import link_rx_pkg::*;
(
  input  logic [15:0] sym_data,
  input  logic        sym_k_lo,
  input  logic        sym_k_hi,
  output sym_cls_t    cls
);

  logic [7:0] lo_b;
  logic [7:0] hi_b;
  logic       lo_bad;
  logic       hi_bad;
  logic       both_k;
  logic       same_b;

  assign lo_b   = sym_data[7:0];
  assign hi_b   = sym_data[15:8];
  assign lo_bad = sym_k_lo && ((lo_b == KC_FAULT) || (lo_b == KC_LOSS));
  assign hi_bad = sym_k_hi && ((hi_b == KC_FAULT) || (hi_b == KC_LOSS));
  assign both_k = sym_k_lo && sym_k_hi;
  assign same_b = (lo_b == hi_b);

  always_comb begin
    cls = SYM_OTHER;
    if (lo_bad || hi_bad) begin
      cls = SYM_FAULT;                                   // R5
    end else if (!sym_k_lo && !sym_k_hi) begin
      cls = SYM_DATA;
    end else if (sym_k_hi && !sym_k_lo && hi_b == KC_FILL_HI && lo_b == DC_FILL_LO) begin
      cls = SYM_FILL;                                    // R1
    end else if (both_k && same_b) begin
      case (lo_b)
        KC_SOP:    cls = SYM_SOP;
        KC_EOP:    cls = SYM_EOP;
        KC_RESUME: cls = SYM_RESUME;
        KC_PAUSE:  cls = SYM_PAUSE;
        default:   cls = SYM_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/link_rx_framer.sv
module link_rx_framer
  import link_rx_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  sym_cls_t    cls,
  input  logic [15:0] sym_data,
  output logic        emit_req,
  output beat_t       emit_beat,
  output logic        pkt_start,
  output logic        stray_hit,
  output logic        crc_fail
);

  fr_state_t   state_q, state_d;
  logic [15:0] lo_q, lo_d;
  logic        lo_en;
  logic [31:0] held_q, held_d;
  logic        held_sop_q, held_sop_d;
  logic        held_en;
  logic        held_v_q, held_v_d;
  logic        first_q, first_d;
  logic [15:0] crc_q, crc_d;
  logic        crc_en;
  logic        crc_fail_q, crc_fail_d;
  logic        in_pkt;
  logic        abort;
  logic [15:0] crc_next;

  assign in_pkt   = (state_q != FR_OUT);
  assign crc_next = crc16_step(crc_q, sym_data, CRC_POLY);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    lo_d       = lo_q;
    lo_en      = 1'b0;
    held_d     = held_q;
    held_sop_d = held_sop_q;
    held_en    = 1'b0;
    held_v_d   = held_v_q;
    first_d    = first_q;
    crc_d      = crc_q;
    crc_en     = 1'b0;
    crc_fail_d = 1'b0;
    emit_req   = 1'b0;
    emit_beat  = '{data: held_q, sop: held_sop_q, eop: 1'b0, err: 1'b0};
    pkt_start  = 1'b0;
    stray_hit  = 1'b0;
    abort      = 1'b0;

    case (cls)
      SYM_SOP: begin
        // R6: an open packet is closed with an error, new one begins
        abort     = in_pkt;
        pkt_start = 1'b1;
        state_d   = FR_LO;
        crc_d     = CRC_INIT;
        crc_en    = 1'b1;
        first_d   = 1'b1;
      end
      SYM_FAULT: begin
        abort = in_pkt;                                  // R5
        if (in_pkt) state_d = FR_OUT;
      end
      SYM_EOP: begin
        case (state_q)
          FR_LO:          state_d = FR_CHK;
          FR_HI, FR_CHK: begin
            abort   = 1'b1;                              // R5 odd length
            state_d = FR_OUT;
          end
          default: ;
        endcase
      end
      SYM_DATA: begin
        case (state_q)
          FR_OUT: stray_hit = 1'b1;                      // R7
          FR_LO: begin
            lo_d    = sym_data;                          // R2 low half first
            lo_en   = 1'b1;
            crc_d   = crc_next;
            crc_en  = 1'b1;
            state_d = FR_HI;
          end
          FR_HI: begin
            crc_d      = crc_next;
            crc_en     = 1'b1;
            emit_req   = held_v_q;
            held_d     = {sym_data, lo_q};
            held_sop_d = first_q;
            held_en    = 1'b1;
            held_v_d   = 1'b1;
            first_d    = 1'b0;
            state_d    = FR_LO;
          end
          FR_CHK: begin
            emit_req      = held_v_q;
            emit_beat.eop = 1'b1;
            crc_fail_d    = held_v_q && (crc_q != sym_data); // R3
            held_v_d      = 1'b0;
            state_d       = FR_OUT;
          end
          default: ;
        endcase
      end
      default: ;                                         // fill, flow, other
    endcase

    if (abort) begin
      emit_req      = held_v_q;
      emit_beat.eop = 1'b1;
      emit_beat.err = 1'b1;
      held_v_d      = 1'b0;
    end
    if (cls == SYM_SOP) held_v_d = 1'b0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FR_OUT;
      lo_q       <= '0;
      held_q     <= '0;
      held_sop_q <= 1'b0;
      held_v_q   <= 1'b0;
      first_q    <= 1'b0;
      crc_q      <= CRC_INIT;
      crc_fail_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      held_v_q   <= held_v_d;
      first_q    <= first_d;
      crc_fail_q <= crc_fail_d;
      if (lo_en) lo_q <= lo_d;
      if (held_en) begin
        held_q     <= held_d;
        held_sop_q <= held_sop_d;
      end
      if (crc_en) crc_q <= crc_d;
    end
  end

  assign crc_fail = crc_fail_q;

  AST_CRC_AT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    crc_fail_q |-> $past(state_q == FR_CHK));             // R3

  AST_SOP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == SYM_SOP) |=> (state_q == FR_LO));             // R6

endmodule

// File: rtl/link_rx_events.sv
module link_rx_events
  import link_rx_pkg::*;
#(
  parameter int STRAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sym_cls_t           cls,
  input  logic               stray_hit,
  output logic               xon_pulse,
  output logic               xoff_pulse,
  output logic [STRAY_W-1:0] stray_count
);

  localparam logic [STRAY_W-1:0] CNT_MAX = {STRAY_W{1'b1}};

  logic               xon_q, xon_d;
  logic               xoff_q, xoff_d;
  logic [STRAY_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    xon_d  = (cls == SYM_RESUME);
    xoff_d = (cls == SYM_PAUSE);
    cnt_en = stray_hit && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xon_q  <= 1'b0;
      xoff_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      xon_q  <= xon_d;
      xoff_q <= xoff_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign xon_pulse   = xon_q;
  assign xoff_pulse  = xoff_q;
  assign stray_count = cnt_q;

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == SYM_RESUME) |=> xon_q);                       // R4

  AST_FLOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xon_q && xoff_q));                                  // R4

  AST_STRAY_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= $past(cnt_q));                               // R7

endmodule

// File: rtl/link_rx_outstage.sv
module link_rx_outstage
  import link_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  emit_req,
  input  beat_t emit_beat,
  input  logic  pkt_start,
  input  logic  out_ready,
  output logic  out_valid,
  output beat_t out_beat,
  output logic  overrun
);

  logic  valid_q, valid_d;
  beat_t beat_q;
  logic  load;
  logic  blocked;
  logic  drop_q, drop_d;
  logic  ovr_q, ovr_d;
  logic  slot_free;

  always_comb begin
    slot_free = !valid_q || out_ready;
    load      = emit_req && !drop_q && slot_free;
    blocked   = emit_req && !drop_q && !slot_free;       // R8
    ovr_d     = blocked;
    drop_d    = pkt_start ? 1'b0 : (drop_q || blocked);
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      drop_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      drop_q  <= drop_d;
      ovr_q   <= ovr_d;
      if (load) beat_q <= emit_beat;
    end
  end

  assign out_valid = valid_q;
  assign out_beat  = beat_q;
  assign overrun   = ovr_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(beat_q))); // R8

  AST_OVR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> $past(valid_q && !out_ready));              // R8

  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && beat_q.err) |-> beat_q.eop);              // R5

endmodule

// File: rtl/link_pkt_rx.sv
module link_pkt_rx
  import link_rx_pkg::*;
#(
  parameter int          STRAY_W  = 8,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        sym_data,
  input  logic               sym_k_lo,
  input  logic               sym_k_hi,
  output logic [31:0]        out_data,
  output logic               out_sop,
  output logic               out_eop,
  output logic               out_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               crc_error,
  output logic               xon_pulse,
  output logic               xoff_pulse,
  output logic               overrun,
  output logic [STRAY_W-1:0] stray_count
);

  logic     rst_meta_q;
  logic     rst_sync_q;
  sym_cls_t cls;
  logic     emit_req;
  beat_t    emit_beat;
  logic     pkt_start;
  logic     stray_hit;
  beat_t    beat;

  // Asynchronous assert, synchronous release (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  link_sym_decode i_decode (
    .sym_data (sym_data),
    .sym_k_lo (sym_k_lo),
    .sym_k_hi (sym_k_hi),
    .cls      (cls)
  );

  link_rx_framer #(
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT)
  ) i_framer (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .cls       (cls),
    .sym_data  (sym_data),
    .emit_req  (emit_req),
    .emit_beat (emit_beat),
    .pkt_start (pkt_start),
    .stray_hit (stray_hit),
    .crc_fail  (crc_error)
  );

  link_rx_outstage i_outstage (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .emit_req  (emit_req),
    .emit_beat (emit_beat),
    .pkt_start (pkt_start),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_beat  (beat),
    .overrun   (overrun)
  );

  link_rx_events #(
    .STRAY_W (STRAY_W)
  ) i_events (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cls         (cls),
    .stray_hit   (stray_hit),
    .xon_pulse   (xon_pulse),
    .xoff_pulse  (xoff_pulse),
    .stray_count (stray_count)
  );

  assign out_data = beat.data;
  assign out_sop  = beat.sop;
  assign out_eop  = beat.eop;
  assign out_err  = beat.err;

  AST_FILL_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((cls == SYM_FILL) && (!out_valid || out_ready)) |=> !out_valid); // R1

  AST_WORD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($rose(out_valid) && !out_err) |-> $past(cls == SYM_DATA)); // R2

endmodule

// File: tb/test_link_pkt_rx.sv
`timescale 1ns/1ps
module test_link_pkt_rx;

  localparam int STRAY_W = 8;

  logic               clk;
  logic               rst_n;
  logic [15:0]        sym_data;
  logic               sym_k_lo;
  logic               sym_k_hi;
  logic [31:0]        out_data;
  logic               out_sop;
  logic               out_eop;
  logic               out_err;
  logic               out_valid;
  logic               out_ready;
  logic               crc_error;
  logic               xon_pulse;
  logic               xoff_pulse;
  logic               overrun;
  logic [STRAY_W-1:0] stray_count;

  int checks = 0;
  int fails  = 0;
  logic [15:0] run_crc;

  link_pkt_rx #(.STRAY_W(STRAY_W)) i_link_pkt_rx (
    .clk(clk), .rst_n(rst_n), .sym_data(sym_data), .sym_k_lo(sym_k_lo),
    .sym_k_hi(sym_k_hi), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err), .out_valid(out_valid),
    .out_ready(out_ready), .crc_error(crc_error), .xon_pulse(xon_pulse),
    .xoff_pulse(xoff_pulse), .overrun(overrun), .stray_count(stray_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: kind 0 raw, 1 good CRC, 2 corrupted CRC
  typedef struct packed {
    logic [1:0]  kind;
    logic        kh;
    logic        kl;
    logic [15:0] d;
    logic        ev;
    logic [31:0] ed;
    logic        es;
    logic        ee;
    logic        er;
    logic        ec;
    logic        exon;
    logic        exoff;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b1,1'b0,16'hBCC5,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1}, // R1 fill
    '{2'd0,1'b1,1'b1,16'hDCDC,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 start
    '{2'd0,1'b0,1'b0,16'h1111,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{2'd0,1'b0,1'b0,16'h2222,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{2'd0,1'b1,1'b0,16'hBCC5,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1}, // R1 mid-packet fill
    '{2'd0,1'b0,1'b0,16'h3333,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1},
    '{2'd0,1'b1,1'b1,16'h5C5C,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd4}, // R4 resume inside
    '{2'd0,1'b0,1'b0,16'h4444,1'b1,32'h22221111,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 first word
    '{2'd0,1'b1,1'b1,16'h9C9C,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 end
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,32'h44443333,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 good crc
    '{2'd0,1'b1,1'b0,16'hBCC5,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd1},
    '{2'd0,1'b1,1'b1,16'h7C7C,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd4}, // R4 pause
    '{2'd0,1'b1,1'b1,16'hDCDC,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{2'd0,1'b0,1'b0,16'hAAAA,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{2'd0,1'b0,1'b0,16'hBBBB,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{2'd0,1'b1,1'b1,16'h9C9C,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{2'd2,1'b0,1'b0,16'h0000,1'b1,32'hBBBBAAAA,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'd3}, // R3 bad crc
    '{2'd0,1'b1,1'b1,16'hDCDC,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{2'd0,1'b0,1'b0,16'h0001,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{2'd0,1'b0,1'b0,16'h0002,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5},
    '{2'd0,1'b1,1'b1,16'hFFFF,1'b1,32'h00020001,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd5}, // R5 loss aborts
    '{2'd0,1'b0,1'b0,16'h5555,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd7}, // R7 stray
    '{2'd0,1'b1,1'b1,16'hDCDC,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{2'd0,1'b0,1'b0,16'h0010,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{2'd0,1'b0,1'b0,16'h0020,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{2'd0,1'b1,1'b1,16'hDCDC,1'b1,32'h00200010,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 restart
    '{2'd0,1'b0,1'b0,16'h0030,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{2'd0,1'b0,1'b0,16'h0040,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{2'd0,1'b1,1'b1,16'h9C9C,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},
    '{2'd1,1'b0,1'b0,16'h0000,1'b1,32'h00400030,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 fresh crc
    '{2'd0,1'b0,1'b1,16'h0000,1'b0,32'h0,       1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd5}  // R5 fault outside
  };

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c;
    for (int b = 15; b >= 0; b--) begin
      logic t;
      t = r[15] ^ w[b];
      r = {r[14:0], 1'b0};
      if (t) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic kh, input logic kl, input logic [15:0] d);
    @(negedge clk);
    sym_k_hi = kh;
    sym_k_lo = kl;
    sym_data = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] obs();
    return {25'd0, out_valid, (out_valid ? out_data : 32'd0),
            out_valid & out_sop, out_valid & out_eop, out_valid & out_err,
            crc_error, xon_pulse, xoff_pulse};
  endfunction

  task automatic fill();
    put(1'b1, 1'b0, 16'hBCC5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    out_ready = 1'b1;
    sym_k_hi  = 1'b1;
    sym_k_lo  = 1'b0;
    sym_data  = 16'hBCC5;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 reset outputs", {obs(), 8'd0} , {64'd0, 8'd0});
    chk("R9 reset counter", {56'd0, stray_count}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Vector table walk
    run_crc = 16'hFFFF;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [15:0] d;
      v = VEC[i];
      d = v.d;
      if (v.kind == 2'd1) d = run_crc;
      if (v.kind == 2'd2) d = run_crc ^ 16'h0001;
      if (v.kind == 2'd0 && v.kh && v.kl && v.d == 16'hDCDC) run_crc = 16'hFFFF;
      else if (v.kind == 2'd0 && !v.kh && !v.kl) run_crc = ref_crc(run_crc, v.d);
      put(v.kh, v.kl, d);
      chk($sformatf("R%0d vector %0d", v.req, i), obs(),
          {25'd0, v.ev, v.ed, v.es, v.ee, v.er, v.ec, v.exon, v.exoff});
    end

    // R7 one stray symbol counted in the table
    chk("R7 stray count after table", {56'd0, stray_count}, 64'd1);

    // R5 end after odd number of data symbols aborts
    put(1'b1, 1'b1, 16'hDCDC);
    put(1'b0, 1'b0, 16'h00A1);
    put(1'b0, 1'b0, 16'h00A2);
    put(1'b0, 1'b0, 16'h00A3);
    put(1'b1, 1'b1, 16'h9C9C);
    chk("R5 odd length abort", obs(), {25'd0, 1'b1, 32'h00A200A1, 1'b1, 1'b1, 1'b1, 3'b000});
    fill();

    // R8 backpressure: hold, drop tail, overrun, crc still checked
    out_ready = 1'b0;
    run_crc = 16'hFFFF;
    put(1'b1, 1'b1, 16'hDCDC);
    for (int k = 1; k <= 6; k++) begin
      logic [15:0] w;
      w = {k[7:0], k[7:0]};
      run_crc = ref_crc(run_crc, w);
      put(1'b0, 1'b0, w);
      if (k == 4)
        chk("R8 first word loaded", obs(), {25'd0, 1'b1, 32'h02020101, 1'b1, 1'b0, 1'b0, 3'b000});
      if (k == 6) begin
        chk("R8 overrun pulse", {63'd0, overrun}, 64'd1);
        chk("R8 word held stable", {32'd0, out_data}, {32'd0, 32'h02020101});
      end
    end
    put(1'b1, 1'b1, 16'h9C9C);
    chk("R8 overrun is one cycle", {63'd0, overrun}, 64'd0);
    put(1'b0, 1'b0, run_crc ^ 16'h8000);
    chk("R8 crc still checked, tail dropped", obs(),
        {25'd0, 1'b1, 32'h02020101, 1'b1, 1'b0, 1'b0, 3'b100});
    @(negedge clk);
    out_ready = 1'b1;
    sym_k_hi = 1'b1; sym_k_lo = 1'b0; sym_data = 16'hBCC5;
    @(posedge clk);
    #1;
    chk("R8 word taken after ready", {63'd0, out_valid}, 64'd0);
    fill();
    chk("R8 dropped tail never appears", {63'd0, out_valid}, 64'd0);

    // R7 saturation
    for (int k = 0; k < 300; k++) put(1'b0, 1'b0, 16'h1234);
    chk("R7 stray count saturates", {56'd0, stray_count}, 64'd255);

    // R9 asynchronous reset with a word pending
    out_ready = 1'b0;
    put(1'b1, 1'b1, 16'hDCDC);
    put(1'b0, 1'b0, 16'h0101);
    put(1'b0, 1'b0, 16'h0202);
    put(1'b0, 1'b0, 16'h0303);
    put(1'b0, 1'b0, 16'h0404);
    chk("R9 word pending before reset", {63'd0, out_valid}, 64'd1);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R9 async reset clears outputs", {obs(), 8'd0}, {64'd0, 8'd0});
    chk("R9 async reset clears counter", {56'd0, stray_count}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule